// File: doc/BRIEF.md
# Automatic DSD/PCM Input Mode Detector

This block watches the clocks of a digital audio input and decides whether the stream carries word-clocked PCM data or one-bit DSD data. It runs entirely from the incoming bit clock and needs no master clock. The word clock is brought into the bit-clock domain through a two-flop synchronizer and an edge detector. Two clock-presence tests decide the mode. If the word clock stays quiet for a run of bit-clock cycles, the input is taken as DSD. If the word clock shows rising edges while the block is in DSD, the input is taken as PCM again.

A switch is allowed only while both channel data inputs have stayed at zero for a programmable run of bit-clock cycles. Any non-zero bit on either channel restarts that run. Each switch produces a one-cycle change flag and starts an internal reset pulse that lasts four word periods. The same pulse is also held while the power-down input is low and for a short time after reset. Detection is gated by an enable input. Power-down forces the block back to PCM.

Top module: `auto_mode_det`

## Requirements
- R1: While `rst` is high and afterwards, until the first switch, `mode_dsd` is 0 (PCM) and `mode_chg` is 0. `int_rst` is 1 during reset and for RST_LEN-1 cycles after reset is released, where RST_LEN = 4*WORD_BCK.
- R2: In PCM, with `det_en`=1, `pwr_on`=1 and the zero-run condition met, `mode_dsd` goes to 1 once DSD_IDLE (default 256) bit-clock cycles have passed since the last synchronized word-clock edge.
- R3: In DSD, with `det_en`=1, `pwr_on`=1 and the zero-run condition met, `mode_dsd` returns to 0 after PCM_EDGES (default 2) synchronized rising edges of `wck` have been seen since entering DSD.
- R4: A switch needs the zero run to be at least ZERO_BASE << `zero_sel` cycles. `zero_sel` values 0..3 give 1x, 2x, 4x and 8x ZERO_BASE. The run counts consecutive cycles with `dat_l`=0 and `dat_r`=0, and a 1 on either input restarts it.
- R5: With `det_en`=0 the mode never changes, whatever the clock and data activity.
- R6: While `pwr_on` is 0, `mode_dsd` is forced to 0, `int_rst` is held at 1 and the idle and zero-run counts are cleared. `int_rst` stays at 1 for RST_LEN-1 further cycles after `pwr_on` returns high.
- R7: `mode_chg` is high for exactly the one cycle in which `mode_dsd` takes its new value, and at no other time.
- R8: Each switch drives `int_rst` high for exactly RST_LEN bit-clock cycles, starting in the cycle the mode changes.
- R9: In PCM, every word-clock edge (rising or falling) restarts the idle count. A running word clock therefore keeps the block in PCM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bck | input | 1 | Bit clock; the only clock of the block |
| rst | input | 1 | Synchronous active-high reset |
| det_en | input | 1 | Enables automatic mode switching |
| pwr_on | input | 1 | Power-down release; low forces PCM and holds internal reset |
| wck | input | 1 | Word clock, asynchronous to bck |
| zero_sel | input | 2 | Zero-run window select (ZERO_BASE << zero_sel) |
| dat_l | input | 1 | Left channel serial data |
| dat_r | input | 1 | Right channel serial data |
| mode_dsd | output | 1 | Current mode: 0 = PCM, 1 = DSD |
| mode_chg | output | 1 | One-cycle flag when the mode changes |
| int_rst | output | 1 | Internal reset for the downstream datapath |

## Verification
The checker looks at every cycle. It confirms that the change flag goes with a real flip of the mode, that every flip raises the internal reset, that a flip occurs only while detection is enabled and after a zero data bit, and that power-down forces PCM with the reset held. Some behaviours can only be shown by the bench scenarios, compared cycle by cycle against a behavioural model. These are the exact 256-cycle quiet threshold, the count of word-clock rising edges needed to return to PCM, the effect of each window select, the exact length of the reset pulse, and the fact that a running word clock keeps the block in PCM.

// File: rtl/amd_pkg.sv
package amd_pkg;
  typedef enum logic {
    MODE_PCM = 1'b0,
    MODE_DSD = 1'b1
  } amd_mode_e;
endpackage

// File: rtl/amd_wck_sync.sv
module amd_wck_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic edge_any,
  output logic edge_rise
);
  logic [2:0] pipe_q;

  always_ff @(posedge clk) begin
    if (rst) pipe_q <= '0;
    else     pipe_q <= {pipe_q[1:0], async_in};
  end

  // pipe_q[1] is the synchronized level, pipe_q[2] its previous value
  assign edge_any  = pipe_q[1] ^ pipe_q[2];
  assign edge_rise = pipe_q[1] & ~pipe_q[2];
endmodule

// File: rtl/amd_run_counter.sv
module amd_run_counter #(
  parameter int LIMIT = 256,
  localparam int W    = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr,
  output logic [W-1:0] cnt
);
  localparam logic [W-1:0] LIM = W'(LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clr)     cnt <= '0;
    else if (cnt != LIM) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/amd_mode_fsm.sv
module amd_mode_fsm
  import amd_pkg::*;
#(
  parameter int PCM_EDGES = 2,
  parameter int RST_LEN   = 256,
  localparam int EW       = $clog2(PCM_EDGES + 1),
  localparam int RW       = $clog2(RST_LEN + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_on,
  input  logic det_en,
  input  logic silent,
  input  logic idle_full,
  input  logic wck_rise,
  output logic mode_dsd,
  output logic mode_chg,
  output logic int_rst
);
  localparam logic [EW-1:0] EDGE_LIM = EW'(PCM_EDGES);
  localparam logic [RW-1:0] RST_LAST = RW'(RST_LEN - 1);

  amd_mode_e   mode_q;
  logic [EW-1:0] rise_cnt;
  logic [RW-1:0] rst_left;
  logic        to_dsd, to_pcm, flip;

  always_comb begin
    to_dsd = det_en && (mode_q == MODE_PCM) && silent && idle_full;
    to_pcm = det_en && (mode_q == MODE_DSD) && silent && (rise_cnt == EDGE_LIM);
    flip   = to_dsd || to_pcm;
  end

  always_ff @(posedge clk) begin
    if (rst || !pwr_on) begin
      mode_q   <= MODE_PCM;
      mode_chg <= 1'b0;
      rise_cnt <= '0;
      rst_left <= RST_LAST;
      int_rst  <= 1'b1;
    end else begin
      mode_chg <= flip;
      if (flip) mode_q <= (mode_q == MODE_PCM) ? MODE_DSD : MODE_PCM;

      if (mode_q == MODE_PCM || flip)          rise_cnt <= '0;
      else if (wck_rise && rise_cnt != EDGE_LIM) rise_cnt <= rise_cnt + 1'b1;

      if (flip) begin
        rst_left <= RST_LAST;
        int_rst  <= 1'b1;
      end else if (rst_left != '0) begin
        rst_left <= rst_left - 1'b1;
        int_rst  <= 1'b1;
      end else begin
        int_rst  <= 1'b0;
      end
    end
  end

  assign mode_dsd = (mode_q == MODE_DSD);
endmodule

// File: rtl/auto_mode_det.sv
module auto_mode_det #(
  parameter int ZERO_BASE = 1024,
  parameter int DSD_IDLE  = 256,
  parameter int PCM_EDGES = 2,
  parameter int WORD_BCK  = 64,
  localparam int ZMAX     = ZERO_BASE * 8,
  localparam int ZW       = $clog2(ZMAX + 1),
  localparam int IW       = $clog2(DSD_IDLE + 1),
  localparam int RST_LEN  = 4 * WORD_BCK
) (
  input  logic       bck,
  input  logic       rst,
  input  logic       det_en,
  input  logic       pwr_on,
  input  logic       wck,
  input  logic [1:0] zero_sel,
  input  logic       dat_l,
  input  logic       dat_r,
  output logic       mode_dsd,
  output logic       mode_chg,
  output logic       int_rst
);
  logic          wck_edge, wck_rise;
  logic [IW-1:0] idle_cnt;
  logic [ZW-1:0] zero_cnt;
  logic [ZW-1:0] win;
  logic          silent, idle_full;

  amd_wck_sync u_sync (
    .clk       (bck),
    .rst       (rst),
    .async_in  (wck),
    .edge_any  (wck_edge),
    .edge_rise (wck_rise)
  );

  amd_run_counter #(.LIMIT(DSD_IDLE)) u_idle (
    .clk (bck),
    .rst (rst),
    .clr (wck_edge || !pwr_on),
    .cnt (idle_cnt)
  );

  amd_run_counter #(.LIMIT(ZMAX)) u_zero (
    .clk (bck),
    .rst (rst),
    .clr (dat_l || dat_r || !pwr_on),
    .cnt (zero_cnt)
  );

  always_comb begin
    win       = ZW'(ZERO_BASE) << zero_sel;
    silent    = (zero_cnt >= win);
    idle_full = (idle_cnt == IW'(DSD_IDLE));
  end

  amd_mode_fsm #(.PCM_EDGES(PCM_EDGES), .RST_LEN(RST_LEN)) u_fsm (
    .clk       (bck),
    .rst       (rst),
    .pwr_on    (pwr_on),
    .det_en    (det_en),
    .silent    (silent),
    .idle_full (idle_full),
    .wck_rise  (wck_rise),
    .mode_dsd  (mode_dsd),
    .mode_chg  (mode_chg),
    .int_rst   (int_rst)
  );
endmodule

// File: rtl/amd_checker.sv
module amd_checker (
  input logic bck,
  input logic rst,
  input logic det_en,
  input logic pwr_on,
  input logic dat_l,
  input logic dat_r,
  input logic mode_dsd,
  input logic mode_chg,
  input logic int_rst
);
  // R7: the flag marks a real flip of the mode
  a_r7_chg_means_flip: assert property (@(posedge bck) disable iff (rst)
    mode_chg |-> (mode_dsd != $past(mode_dsd)));

  // R7: every flip of the mode carries the flag
  a_r7_flip_has_flag: assert property (@(posedge bck) disable iff (rst)
    (mode_dsd != $past(mode_dsd)) |-> (mode_chg || $past(!pwr_on)));

  // R8: a switch always raises the internal reset
  a_r8_rst_on_switch: assert property (@(posedge bck) disable iff (rst)
    mode_chg |-> int_rst);

  // R5: no switch without the enable in the deciding cycle
  a_r5_enable_gates: assert property (@(posedge bck) disable iff (rst)
    mode_chg |-> $past(det_en));

  // R4: the data bit sampled just before the decision was zero
  a_r4_silent_data: assert property (@(posedge bck) disable iff (rst)
    mode_chg |-> $past(!(dat_l || dat_r), 2));

  // R6: power-down forces PCM with reset held
  a_r6_powerdown: assert property (@(posedge bck) disable iff (rst)
    $past(!pwr_on) |-> (!mode_dsd && int_rst && !mode_chg));
endmodule

bind auto_mode_det amd_checker u_amd_checker (
  .bck      (bck),
  .rst      (rst),
  .det_en   (det_en),
  .pwr_on   (pwr_on),
  .dat_l    (dat_l),
  .dat_r    (dat_r),
  .mode_dsd (mode_dsd),
  .mode_chg (mode_chg),
  .int_rst  (int_rst)
);

// File: tb/auto_mode_det_bench.sv
module auto_mode_det_bench;
  localparam int CLK_PERIOD = 10;
  localparam int ZB    = 16;
  localparam int IDLE  = 256;
  localparam int EDGES = 2;
  localparam int WB    = 8;
  localparam int RLEN  = 4 * WB;
  localparam int ZMAXB = ZB * 8;

  logic bck = 1'b0;
  logic rst, det_en, pwr_on, wck, dat_l, dat_r;
  logic [1:0] zero_sel;
  logic mode_dsd, mode_chg, int_rst;

  always #(CLK_PERIOD / 2) bck = ~bck;

  auto_mode_det #(.ZERO_BASE(ZB), .DSD_IDLE(IDLE), .PCM_EDGES(EDGES), .WORD_BCK(WB))
    u_auto_mode_det (
      .bck(bck), .rst(rst), .det_en(det_en), .pwr_on(pwr_on), .wck(wck),
      .zero_sel(zero_sel), .dat_l(dat_l), .dat_r(dat_r),
      .mode_dsd(mode_dsd), .mode_chg(mode_chg), .int_rst(int_rst));

  int checks = 0;
  int fails  = 0;
  string phase = "R1";

  // reference state
  bit wq[$];
  int m_idle, m_zero, m_rise, m_left;
  bit m_mode, m_chg, m_irst;
  bit wck_run;
  int wph;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit e_any, e_rise, sw, silent;
    if (rst) begin
      wq = '{0, 0, 0};
      m_idle = 0; m_zero = 0; m_rise = 0; m_mode = 0; m_chg = 0;
      m_left = RLEN - 1; m_irst = 1;
      return;
    end
    e_any  = (wq[1] != wq[0]);
    e_rise = wq[1] && !wq[0];
    silent = (m_zero >= (ZB << zero_sel));
    if (!pwr_on) begin
      m_idle = 0; m_zero = 0; m_rise = 0; m_mode = 0; m_chg = 0;
      m_left = RLEN - 1; m_irst = 1;
    end else begin
      sw = det_en && silent &&
           ((!m_mode && m_idle == IDLE) || (m_mode && m_rise == EDGES));
      m_idle = e_any ? 0 : (m_idle < IDLE ? m_idle + 1 : IDLE);
      m_zero = (dat_l || dat_r) ? 0 : (m_zero < ZMAXB ? m_zero + 1 : ZMAXB);
      if (!m_mode || sw) m_rise = 0;
      else if (e_rise && m_rise < EDGES) m_rise++;
      m_chg = sw;
      if (sw) m_mode = !m_mode;
      if (sw) begin m_left = RLEN - 1; m_irst = 1; end
      else if (m_left != 0) begin m_left--; m_irst = 1; end
      else m_irst = 0;
    end
    // history: wq[2]=newest sample, wq[1]=sync level, wq[0]=previous level
    wq.push_back(wck);
    void'(wq.pop_front());
  endtask

  task automatic cyc();
    if (wck_run) begin
      wph++;
      if (wph >= WB / 2) begin wph = 0; wck = ~wck; end
    end else begin
      wck = 1'b0;
    end
    model_step();
    @(negedge bck);
    chk(phase, {mode_dsd, mode_chg, int_rst}, {m_mode, m_chg, m_irst});
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    repeat (200000) @(posedge bck);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int pulses, hi;
    rst = 1; det_en = 1; pwr_on = 1; wck = 0; dat_l = 0; dat_r = 0;
    zero_sel = 2'd0; wck_run = 0; wph = 0;
    wq = '{0, 0, 0};
    // R1: reset state
    phase = "R1";
    run(3);
    chk("R1 mode", mode_dsd, 0);
    chk("R1 int_rst", int_rst, 1);
    rst = 0;
    wck_run = 1;
    run(40);
    chk("R1 reset pulse ended", int_rst, 0);

    // R9: running word clock keeps PCM
    phase = "R9";
    run(600);
    chk("R9 stays PCM", mode_dsd, 0);

    // R2/R7/R8: word clock stops, switch to DSD
    phase = "R2";
    wck_run = 0;
    run(250);
    chk("R2 not before threshold", mode_dsd, 0);
    pulses = 0; hi = 0;
    for (int i = 0; i < 150; i++) begin
      cyc();
      if (mode_chg) pulses++;
      if (int_rst) hi++;
    end
    chk("R2 now DSD", mode_dsd, 1);
    chk("R7 one flag", pulses, 1);
    chk("R8 pulse length", hi, RLEN);

    // R4: non-zero data blocks the return to PCM
    phase = "R4";
    wck_run = 1;
    for (int i = 0; i < 200; i++) begin
      dat_l = (i % 10 == 0);
      dat_r = (i % 10 == 5);
      cyc();
    end
    chk("R4 blocked by data", mode_dsd, 1);

    // R3: silence with word clock returns to PCM
    phase = "R3";
    dat_l = 0; dat_r = 0;
    run(60);
    chk("R3 back to PCM", mode_dsd, 0);

    // R5: disabled detection never switches
    phase = "R5";
    det_en = 0; wck_run = 0;
    run(400);
    chk("R5 no switch", mode_dsd, 0);

    // R4: 8x window after a non-zero bit
    phase = "R4";
    zero_sel = 2'd3; dat_r = 1;
    run(1);
    dat_r = 0; det_en = 1;
    run(100);
    chk("R4 window 8x not yet", mode_dsd, 0);
    run(50);
    chk("R4 window 8x reached", mode_dsd, 1);

    // R6: power-down
    phase = "R6";
    pwr_on = 0;
    run(5);
    chk("R6 forced PCM", mode_dsd, 0);
    chk("R6 reset held", int_rst, 1);
    pwr_on = 1; wck_run = 1;
    run(50);
    chk("R6 reset released", int_rst, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule